// File: doc/BRIEF.md
# Shared Bus Register Datapath

This block is the register-and-storage half of a small accumulator machine. Eight registers of mixed width and a 4096-word by 16-bit memory hang off one 16-bit transfer bus. A 3-bit source select chooses the single source that drives the bus. Each register takes its own synchronous clear, load and increment strobes. The memory is read onto the bus and written from it, always at the word that the address register points to.

An external sequencer drives the strobes each cycle. An external arithmetic unit supplies the accumulator's next value through a dedicated port. Registers narrower than the bus are zero-extended when they drive it. When they load from it they keep only its low bits.

The input register fills from its own 8-bit port. The output register takes the low byte of the bus. Neither has a handshake.

Top module: `bus_datapath`

## Requirements
- R1: While rst_n is low, every register output reads zero.
- R2: The bus carries the source picked by bus_sel: 1 address reg, 2 program counter, 3 data reg, 4 accumulator, 5 instruction reg, 6 temp reg, 7 memory. A select of 0 gives 16'h0000. 12-bit sources appear zero-extended.
- R3: With bus_sel = 7, the bus shows the memory word at the address register's value while mem_rd is 1, and 16'h0000 while mem_rd is 0.
- R4: On a rising edge with mem_wr = 1, the bus value replaces the word at the address register's value. With mem_wr = 0, memory is unchanged.
- R5: A register loading from the bus takes all 16 bits (data, instruction, temp), bits 11:0 (address, program counter) or bits 7:0 (output reg).
- R6: The accumulator loads from ac_in, and the input register loads from inpr_in, not from the bus.
- R7: Increment adds one modulo the register width, so 12'hFFF becomes 12'h000.
- R8: Per register, clear beats load and load beats increment.
- R9: A memory write and register loads in one cycle all use the bus value and address from before the edge.
- Strobe bit order in reg_ld, reg_inc and reg_clr: bit 0 address, 1 program counter, 2 data, 3 accumulator, 4 instruction, 5 temp, 6 input, 7 output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Bus source select |
| reg_ld | input | 8 | Per-register load strobes |
| reg_inc | input | 8 | Per-register increment strobes |
| reg_clr | input | 8 | Per-register clear strobes |
| mem_rd | input | 1 | Memory read enable onto the bus |
| mem_wr | input | 1 | Memory write strobe |
| ac_in | input | 16 | Next accumulator value |
| inpr_in | input | 8 | Next input register value |
| bus_out | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temp register |
| inpr_q | output | 8 | Input register |
| outr_q | output | 8 | Output register |

## Verification
The bus value is combinational, so it is due in the same cycle that the select and read enable are applied. Register outputs change one rising edge after their strobe. A memory write becomes visible only when a later cycle selects memory with mem_rd high. Each expected item carries the cycle number in which it is due. The monitor compares an item only in that cycle, at a point after the stimulus has settled and away from the edge.

// File: rtl/bd_pkg.sv
package bd_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int BYTE_W = 8;
    localparam int NUM_REGS = 8;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_AR   = 3'd1,
        SRC_PC   = 3'd2,
        SRC_DR   = 3'd3,
        SRC_AC   = 3'd4,
        SRC_IR   = 3'd5,
        SRC_TR   = 3'd6,
        SRC_MEM  = 3'd7
    } bus_src_e;

    localparam int IX_AR   = 0;
    localparam int IX_PC   = 1;
    localparam int IX_DR   = 2;
    localparam int IX_AC   = 3;
    localparam int IX_IR   = 4;
    localparam int IX_TR   = 5;
    localparam int IX_INPR = 6;
    localparam int IX_OUTR = 7;
endpackage

// File: rtl/bd_reg.sv
module bd_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic         inc,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end else if (inc) begin
            q <= q + ONE;
        end
    end
endmodule

// File: rtl/bd_mem.sv
module bd_mem #(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) begin
            store[addr] <= wdata;
        end
    end

    assign rdata = store[addr];
endmodule

// File: rtl/bd_bus_mux.sv
module bd_bus_mux
    import bd_pkg::*;
(
    input  logic [2:0]        sel,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] ar,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] dr,
    input  logic [DATA_W-1:0] ac,
    input  logic [DATA_W-1:0] ir,
    input  logic [DATA_W-1:0] tr,
    input  logic [DATA_W-1:0] mem,
    output logic [DATA_W-1:0] bus
);
    localparam int PAD = DATA_W - ADDR_W;

    always_comb begin
        unique case (bus_src_e'(sel))
            SRC_NONE: bus = '0;
            SRC_AR:   bus = {{PAD{1'b0}}, ar};
            SRC_PC:   bus = {{PAD{1'b0}}, pc};
            SRC_DR:   bus = dr;
            SRC_AC:   bus = ac;
            SRC_IR:   bus = ir;
            SRC_TR:   bus = tr;
            SRC_MEM:  bus = rd_en ? mem : '0;
            default:  bus = '0;
        endcase
    end
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
    import bd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_sel,
    input  logic [NUM_REGS-1:0] reg_ld,
    input  logic [NUM_REGS-1:0] reg_inc,
    input  logic [NUM_REGS-1:0] reg_clr,
    input  logic                mem_rd,
    input  logic                mem_wr,
    input  logic [DATA_W-1:0]   ac_in,
    input  logic [BYTE_W-1:0]   inpr_in,
    output logic [DATA_W-1:0]   bus_out,
    output logic [ADDR_W-1:0]   ar_q,
    output logic [ADDR_W-1:0]   pc_q,
    output logic [DATA_W-1:0]   dr_q,
    output logic [DATA_W-1:0]   ac_q,
    output logic [DATA_W-1:0]   ir_q,
    output logic [DATA_W-1:0]   tr_q,
    output logic [BYTE_W-1:0]   inpr_q,
    output logic [BYTE_W-1:0]   outr_q
);
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] bus_w;

    bd_bus_mux u_mux (
        .sel   (bus_sel),
        .rd_en (mem_rd),
        .ar    (ar_q),
        .pc    (pc_q),
        .dr    (dr_q),
        .ac    (ac_q),
        .ir    (ir_q),
        .tr    (tr_q),
        .mem   (mem_rdata),
        .bus   (bus_w)
    );

    bd_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .clk   (clk),
        .wr    (mem_wr),
        .addr  (ar_q),
        .wdata (bus_w),
        .rdata (mem_rdata)
    );

    bd_reg #(.W(ADDR_W)) u_ar (
        .clk(clk), .rst_n(rst_n),
        .clr(reg_clr[IX_AR]), .ld(reg_ld[IX_AR]), .inc(reg_inc[IX_AR]),
        .d(bus_w[ADDR_W-1:0]), .q(ar_q)
    );

    bd_reg #(.W(ADDR_W)) u_pc (
        .clk(clk), .rst_n(rst_n),
        .clr(reg_clr[IX_PC]), .ld(reg_ld[IX_PC]), .inc(reg_inc[IX_PC]),
        .d(bus_w[ADDR_W-1:0]), .q(pc_q)
    );

    bd_reg #(.W(DATA_W)) u_dr (
        .clk(clk), .rst_n(rst_n),
        .clr(reg_clr[IX_DR]), .ld(reg_ld[IX_DR]), .inc(reg_inc[IX_DR]),
        .d(bus_w), .q(dr_q)
    );

    bd_reg #(.W(DATA_W)) u_ac (
        .clk(clk), .rst_n(rst_n),
        .clr(reg_clr[IX_AC]), .ld(reg_ld[IX_AC]), .inc(reg_inc[IX_AC]),
        .d(ac_in), .q(ac_q)
    );

    bd_reg #(.W(DATA_W)) u_ir (
        .clk(clk), .rst_n(rst_n),
        .clr(reg_clr[IX_IR]), .ld(reg_ld[IX_IR]), .inc(reg_inc[IX_IR]),
        .d(bus_w), .q(ir_q)
    );

    bd_reg #(.W(DATA_W)) u_tr (
        .clk(clk), .rst_n(rst_n),
        .clr(reg_clr[IX_TR]), .ld(reg_ld[IX_TR]), .inc(reg_inc[IX_TR]),
        .d(bus_w), .q(tr_q)
    );

    bd_reg #(.W(BYTE_W)) u_inpr (
        .clk(clk), .rst_n(rst_n),
        .clr(reg_clr[IX_INPR]), .ld(reg_ld[IX_INPR]), .inc(reg_inc[IX_INPR]),
        .d(inpr_in), .q(inpr_q)
    );

    bd_reg #(.W(BYTE_W)) u_outr (
        .clk(clk), .rst_n(rst_n),
        .clr(reg_clr[IX_OUTR]), .ld(reg_ld[IX_OUTR]), .inc(reg_inc[IX_OUTR]),
        .d(bus_w[BYTE_W-1:0]), .q(outr_q)
    );

    assign bus_out = bus_w;
endmodule

// File: rtl/bd_checker.sv
module bd_checker
    import bd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          bus_sel,
    input logic [NUM_REGS-1:0] reg_ld,
    input logic [NUM_REGS-1:0] reg_inc,
    input logic [NUM_REGS-1:0] reg_clr,
    input logic                mem_rd,
    input logic [DATA_W-1:0]   bus_out,
    input logic [ADDR_W-1:0]   ar_q,
    input logic [ADDR_W-1:0]   pc_q
);
    a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 3'd0) |-> (bus_out == '0));

    a_r2_ar_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 3'd1) |-> (bus_out == {4'h0, ar_q}));

    a_r3_mem_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 3'd7 && !mem_rd) |-> (bus_out == '0));

    a_r5_pc_takes_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ld[IX_PC] && !reg_clr[IX_PC]) |=> (pc_q == $past(bus_out[ADDR_W-1:0])));

    a_r7_ar_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_inc[IX_AR] && !reg_ld[IX_AR] && !reg_clr[IX_AR]) |=> (ar_q == $past(ar_q) + 12'd1));

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clr[IX_PC] |=> (pc_q == '0));
endmodule

bind bus_datapath bd_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .reg_ld  (reg_ld),
    .reg_inc (reg_inc),
    .reg_clr (reg_clr),
    .mem_rd  (mem_rd),
    .bus_out (bus_out),
    .ar_q    (ar_q),
    .pc_q    (pc_q)
);

// File: tb/bus_datapath_tb.sv
module bus_datapath_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [7:0]  reg_ld = '0, reg_inc = '0, reg_clr = '0;
    logic        mem_rd = 1'b0, mem_wr = 1'b0;
    logic [15:0] ac_in = '0;
    logic [7:0]  inpr_in = '0;
    logic [15:0] bus_out, dr_q, ac_q, ir_q, tr_q;
    logic [11:0] ar_q, pc_q;
    logic [7:0]  inpr_q, outr_q;

    bus_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
        .reg_ld(reg_ld), .reg_inc(reg_inc), .reg_clr(reg_clr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ac_in(ac_in), .inpr_in(inpr_in),
        .bus_out(bus_out), .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q),
        .ir_q(ir_q), .tr_q(tr_q), .inpr_q(inpr_q), .outr_q(outr_q)
    );

    always #10 clk = ~clk;

    // Observation ids: 0 AR,1 PC,2 DR,3 AC,4 IR,5 TR,6 INPR,7 OUTR,8 bus
    typedef struct {
        int          due;
        int          id;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q_exp[$];
    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] observe(input int id);
        case (id)
            0: return {4'h0, ar_q};
            1: return {4'h0, pc_q};
            2: return dr_q;
            3: return ac_q;
            4: return ir_q;
            5: return tr_q;
            6: return {8'h00, inpr_q};
            7: return {8'h00, outr_q};
            default: return bus_out;
        endcase
    endfunction

    task automatic expect_at(input int dly, input int id, input logic [15:0] v, input string req);
        item_t it;
        it.due = cyc + dly;
        it.id  = id;
        it.exp = v;
        it.req = req;
        q_exp.push_back(it);
    endtask

    task automatic next_cycle();
        @(negedge clk);
        bus_sel = '0; reg_ld = '0; reg_inc = '0; reg_clr = '0;
        mem_rd = 1'b0; mem_wr = 1'b0;
    endtask

    // Monitor: compare every item due in this cycle, after inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #5;
            for (int k = q_exp.size() - 1; k >= 0; k--) begin
                if (q_exp[k].due == cyc) begin
                    logic [15:0] act;
                    act = observe(q_exp[k].id);
                    checks++;
                    if (act !== q_exp[k].exp) begin
                        failures++;
                        $display("FAIL %s id=%0d actual=%h expected=%h", q_exp[k].req,
                                 q_exp[k].id, act, q_exp[k].exp);
                    end
                    q_exp.delete(k);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        next_cycle();
        next_cycle();
        // R1: reset state
        for (int i = 0; i < 8; i++) expect_at(0, i, 16'h0000, "R1");
        next_cycle();
        rst_n = 1'b1;
        expect_at(0, 8, 16'h0000, "R2 select 0");

        next_cycle();   // R6: accumulator from ac_in
        ac_in = 16'hBEEF; reg_ld[3] = 1'b1;
        expect_at(1, 3, 16'hBEEF, "R6 ac");

        next_cycle();   // R5: loads of mixed width from the accumulator
        bus_sel = 3'd4; reg_ld[0] = 1'b1; reg_ld[2] = 1'b1; reg_ld[7] = 1'b1;
        expect_at(0, 8, 16'hBEEF, "R2 select ac");
        expect_at(1, 0, 16'h0EEF, "R5 ar low bits");
        expect_at(1, 2, 16'hBEEF, "R5 dr full");
        expect_at(1, 7, 16'h00EF, "R5 outr low byte");

        next_cycle();   // R4: write mem[EEF]
        bus_sel = 3'd4; mem_wr = 1'b1;

        next_cycle();   // R3: read back, load IR
        bus_sel = 3'd7; mem_rd = 1'b1; reg_ld[4] = 1'b1;
        expect_at(0, 8, 16'hBEEF, "R3/R4 read after write");
        expect_at(1, 4, 16'hBEEF, "R5 ir full");

        next_cycle();
        bus_sel = 3'd7;
        expect_at(0, 8, 16'h0000, "R3 read disabled");

        next_cycle();
        bus_sel = 3'd5;
        expect_at(0, 8, 16'hBEEF, "R2 select ir");

        next_cycle();
        bus_sel = 3'd1;
        expect_at(0, 8, 16'h0EEF, "R2 ar zero-extended");

        next_cycle();
        ac_in = 16'h0FFF; reg_ld[3] = 1'b1; inpr_in = 8'hA5; reg_ld[6] = 1'b1;
        expect_at(1, 6, 16'h00A5, "R6 inpr");

        next_cycle();
        bus_sel = 3'd4; reg_ld[1] = 1'b1; reg_inc[5] = 1'b1;
        expect_at(1, 1, 16'h0FFF, "R5 pc");
        expect_at(1, 5, 16'h0001, "R7 tr inc");

        next_cycle();
        reg_inc[1] = 1'b1;
        expect_at(1, 1, 16'h0000, "R7 pc wrap");

        next_cycle();
        bus_sel = 3'd2; reg_inc[2] = 1'b1;
        expect_at(0, 8, 16'h0000, "R2 select pc");
        expect_at(1, 2, 16'hBEF0, "R7 dr inc");

        next_cycle();
        bus_sel = 3'd3; reg_clr[1] = 1'b1; reg_ld[1] = 1'b1; reg_inc[1] = 1'b1;
        expect_at(0, 8, 16'hBEF0, "R2 select dr");
        expect_at(1, 1, 16'h0000, "R8 clear over load");

        next_cycle();
        bus_sel = 3'd3; reg_ld[1] = 1'b1; reg_inc[1] = 1'b1;
        expect_at(1, 1, 16'h0EF0, "R8 load over inc");

        next_cycle();
        reg_clr[5] = 1'b1; reg_inc[5] = 1'b1;
        expect_at(1, 5, 16'h0000, "R8 clear over inc");

        next_cycle();   // R9: write, AR load and DR load in one cycle
        bus_sel = 3'd4; mem_wr = 1'b1; reg_ld[0] = 1'b1; reg_ld[2] = 1'b1;
        ac_in = 16'h1234; reg_ld[3] = 1'b1;
        expect_at(1, 0, 16'h0FFF, "R9 ar");
        expect_at(1, 2, 16'h0FFF, "R9 dr old ac");
        expect_at(1, 3, 16'h1234, "R9 ac");

        next_cycle();
        ac_in = 16'h0EEF; reg_ld[3] = 1'b1;

        next_cycle();
        bus_sel = 3'd4; reg_ld[0] = 1'b1;
        expect_at(1, 0, 16'h0EEF, "R5 ar");

        next_cycle();
        bus_sel = 3'd7; mem_rd = 1'b1;
        expect_at(0, 8, 16'h0FFF, "R9 write used old address");

        next_cycle();   // R4: no write when strobe low
        bus_sel = 3'd6;
        expect_at(0, 8, 16'h0000, "R2 select tr");

        next_cycle();
        bus_sel = 3'd7; mem_rd = 1'b1;
        expect_at(0, 8, 16'h0FFF, "R4 unchanged without write");

        next_cycle();
        next_cycle();
        next_cycle();
        if (q_exp.size() != 0) begin
            failures++;
            $display("FAIL pending items actual=%0d expected=0", q_exp.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule